// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-based processor. A 4-bit operation code picks one of thirteen operations, which act on two 8-bit operands `a_i` (the accumulator or index register) and `b_i` (the memory or immediate operand). The result is produced combinationally in the same cycle. The four status flags (negative, zero, carry, overflow) live in a register inside the block. The carry flag that an operation reads is the one held in that register.

The flag register loads only in a cycle where `flag_upd_i` is high. Even then, each class of operation writes only its own subset of the flags and leaves the others as they were. Decimal arithmetic is not provided, so addition and subtraction are always binary. Fetching operands and writing the result to a register belong to other blocks.

Operation codes: 0 add with carry, 1 subtract with borrow, 2 increment, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 shift left, 8 logical shift right, 9 rotate left through carry, 10 rotate right through carry, 11 compare, 12 transfer. Codes 13 to 15 are unused.

Top module: `alu8_core`

## Requirements
- R1: Code 0 gives `a + b + C` truncated to 8 bits; the new C is the ninth bit of that 9-bit sum.
- R2: After code 0, V is 1 exactly when `a` and `b` share a sign bit (bit 7) and the result's bit 7 differs from it.
- R3: Code 1 gives `a - b - (1 - C)` truncated to 8 bits; the new C is 1 when no borrow occurred (the true difference is at least 0), and V is 1 when the signed difference lies outside -128..127.
- R4: Code 2 gives `a + 1` and code 3 gives `a - 1`, both modulo 256; they write only N and Z, so C and V keep their values.
- R5: Codes 4, 5 and 6 give `a & b`, `a | b` and `a ^ b`, and code 12 gives `b`; they write only N and Z.
- R6: Code 7 gives `a` shifted left with a 0 into bit 0 and old bit 7 into C; code 8 gives `a` shifted right with a 0 into bit 7 and old bit 0 into C; V is kept.
- R7: Code 9 gives `{a[6:0], C}` with old `a[7]` into C; code 10 gives `{C, a[7:1]}` with old `a[0]` into C; V is kept.
- R8: Code 11 leaves the result equal to `a` and sets C = (a >= b), Z = (a == b) and N = (a < b), all unsigned; V is kept.
- R9: For every operation except compare that writes N and Z, N is bit 7 of the result and Z is 1 when all 8 result bits are 0.
- R10: The flags read as all zero after reset, and in a cycle with `flag_upd_i` low no flag changes.
- R11: Codes 13 to 15 give a result equal to `a` and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Register operand |
| b_i | input | 8 | Second operand |
| flag_upd_i | input | 1 | Load the flags affected by this operation |
| result_o | output | 8 | Combinational result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Every operation code is swept over all 256 values of `a`. Each value of `a` is paired with eight values of `b` spread across the range. The carry going in comes from the running flag state, so both carry values reach the add, subtract and rotate paths. Directed cases target the boundaries that tell the rules apart:
- `7F+01` and `80+80` for signed overflow against unsigned carry.
- `00-01` with the borrow in both states.
- An equal, a larger and a smaller operand for compare.
- Increment across `FF` and decrement across `00` with carry set, which shows that carry is kept.
- An op that would change flags, run with the strobe low, which must leave the flags as they were.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_CMP = 4'd11,
    OP_MOV = 4'd12,
    OP_RSV = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic nz;
    logic c;
    logic v;
  } flag_we_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic         sel,
  output logic [W-1:0] res,
  output flags_t       fl,
  output flag_we_t     we
);
  localparam int MSB = W - 1;

  logic [W:0] sum9;
  logic [W:0] dif9;

  always_comb begin
    sum9 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    dif9 = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ~cin};
    sel  = 1'b1;
    res  = a;
    fl   = '0;
    we   = '0;
    case (op)
      OP_ADD: begin
        res  = sum9[W-1:0];
        fl.c = sum9[W];
        fl.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
        we   = '{nz: 1'b1, c: 1'b1, v: 1'b1};
      end
      OP_SUB: begin
        res  = dif9[W-1:0];
        fl.c = ~dif9[W];
        fl.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        we   = '{nz: 1'b1, c: 1'b1, v: 1'b1};
      end
      OP_INC: begin
        res = a + {{(W-1){1'b0}}, 1'b1};
        we  = '{nz: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_DEC: begin
        res = a - {{(W-1){1'b0}}, 1'b1};
        we  = '{nz: 1'b1, c: 1'b0, v: 1'b0};
      end
      OP_CMP: begin
        res = a;
        we  = '{nz: 1'b1, c: 1'b1, v: 1'b0};
      end
      default: sel = 1'b0;
    endcase
    if (op == OP_CMP) begin
      fl.n = (a < b);
      fl.z = (a == b);
      fl.c = (a >= b);
    end else begin
      fl.n = res[MSB];
      fl.z = (res == '0);
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output flags_t       fl,
  output flag_we_t     we
);
  localparam int MSB = W - 1;

  always_comb begin
    res = a;
    fl  = '0;
    we  = '{nz: 1'b1, c: 1'b0, v: 1'b0};
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_MOV: res = b;
      OP_SHL: begin
        res  = {a[MSB-1:0], 1'b0};
        fl.c = a[MSB];
        we.c = 1'b1;
      end
      OP_SHR: begin
        res  = {1'b0, a[MSB:1]};
        fl.c = a[0];
        we.c = 1'b1;
      end
      OP_ROL: begin
        res  = {a[MSB-1:0], cin};
        fl.c = a[MSB];
        we.c = 1'b1;
      end
      OP_ROR: begin
        res  = {cin, a[MSB:1]};
        fl.c = a[0];
        we.c = 1'b1;
      end
      default: begin
        res = a;
        we  = '0;
      end
    endcase
    fl.n = res[MSB];
    fl.z = (res == '0);
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     upd,
  input  flag_we_t we,
  input  flags_t   nxt,
  output flags_t   q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd) begin
      if (we.nz) begin
        q.n <= nxt.n;
        q.z <= nxt.z;
      end
      if (we.c) q.c <= nxt.c;
      if (we.v) q.v <= nxt.v;
    end
  end

  // R10: no strobe, no flag movement
  a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_upd_i,
  output logic [W-1:0] result_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_c_o,
  output logic         flag_v_o
);
  alu_op_e  op;
  flags_t   flags_q;
  flags_t   ar_fl, bo_fl, nxt_fl;
  flag_we_t ar_we, bo_we, nxt_we;
  logic [W-1:0] ar_res, bo_res;
  logic ar_sel;

  assign op = alu_op_e'(op_i);

  alu8_arith #(.W(W)) u_arith (
    .op(op), .a(a_i), .b(b_i), .cin(flags_q.c),
    .sel(ar_sel), .res(ar_res), .fl(ar_fl), .we(ar_we)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op(op), .a(a_i), .b(b_i), .cin(flags_q.c),
    .res(bo_res), .fl(bo_fl), .we(bo_we)
  );

  always_comb begin
    if (ar_sel) begin
      result_o = ar_res;
      nxt_fl   = ar_fl;
      nxt_we   = ar_we;
    end else begin
      result_o = bo_res;
      nxt_fl   = bo_fl;
      nxt_we   = bo_we;
    end
  end

  alu8_flagreg u_flags (
    .clk(clk), .rst(rst), .upd(flag_upd_i),
    .we(nxt_we), .nxt(nxt_fl), .q(flags_q)
  );

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;

  // R1: carry and sum together form the 9-bit total
  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (flag_upd_i && op_i == 4'd0) |=>
      ({flag_c_o, $past(result_o)} ==
       ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(flag_c_o)})));

  // R8: compare flags follow the unsigned ordering, V kept
  a_r8_compare_flags: assert property (@(posedge clk) disable iff (rst)
    (flag_upd_i && op_i == 4'd11) |=>
      (flag_c_o == ($past(a_i) >= $past(b_i)) &&
       flag_z_o == ($past(a_i) == $past(b_i)) &&
       flag_n_o == ($past(a_i) <  $past(b_i)) && $stable(flag_v_o)));

  // R5: logic and transfer ops keep C and V
  a_r5_logic_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    (flag_upd_i && (op_i inside {4'd4, 4'd5, 4'd6, 4'd12})) |=>
      ($stable(flag_c_o) && $stable(flag_v_o)));

  // R11: unused codes pass a and keep every flag
  a_r11_unused_inert: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd13) |-> (result_o == a_i) ##1
      ($stable(flag_n_o) && $stable(flag_z_o) && $stable(flag_c_o) && $stable(flag_v_o)));

  // R9: N and Z mirror the result for non-compare flag writers
  a_r9_nz_mirror: assert property (@(posedge clk) disable iff (rst)
    (flag_upd_i && op_i <= 4'd12 && op_i != 4'd11) |=>
      (flag_n_o == $past(result_o[W-1]) && flag_z_o == ($past(result_o) == '0)));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       upd;
  logic [7:0] result;
  logic       fn, fz, fc, fv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] mflags; // {n,z,c,v}

  alu8_core u_dut (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .flag_upd_i(upd),
    .result_o(result), .flag_n_o(fn), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string rtag(input logic [3:0] o);
    case (o)
      4'd0: return "R1/R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd12: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      4'd11: return "R8";
      default: return "R11";
    endcase
  endfunction

  // reference: returns {result, n, z, c, v}
  function automatic logic [11:0] ref_model(input logic [3:0] o, input int ai, input int bi,
                                            input logic [3:0] f);
    int r; int sa; int sb; int t;
    logic n, z, c, v;
    logic wnz;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    wnz = 1'b1;
    r = ai;
    sa = (ai > 127) ? ai - 256 : ai;
    sb = (bi > 127) ? bi - 256 : bi;
    case (o)
      4'd0: begin t = ai + bi + int'(c); r = t % 256; v = ((sa + sb + int'(c)) > 127) || ((sa + sb + int'(c)) < -128); c = (t > 255); end
      4'd1: begin t = ai - bi - (1 - int'(c)); r = (t + 512) % 256; v = ((sa - sb - (1 - int'(c))) > 127) || ((sa - sb - (1 - int'(c))) < -128); c = (t >= 0); end
      4'd2: r = (ai + 1) % 256;
      4'd3: r = (ai + 255) % 256;
      4'd4: r = ai & bi;
      4'd5: r = ai | bi;
      4'd6: r = ai ^ bi;
      4'd7: begin r = (ai * 2) % 256; c = (ai >= 128); end
      4'd8: begin r = ai / 2; c = ai[0]; end
      4'd9: begin r = (ai * 2) % 256 + int'(c); c = (ai >= 128); end
      4'd10: begin r = ai / 2 + 128 * int'(c); c = ai[0]; end
      4'd11: begin r = ai; wnz = 1'b0; n = (ai < bi); z = (ai == bi); c = (ai >= bi); end
      4'd12: r = bi;
      default: begin r = ai; wnz = 1'b0; end
    endcase
    if (wnz) begin n = (r >= 128); z = (r == 0); end
    return {r[7:0], n, z, c, v};
  endfunction

  task automatic step(input logic [3:0] o, input logic [7:0] av, input logic [7:0] bv, input logic u);
    logic [11:0] exp;
    @(negedge clk);
    op = o; a = av; b = bv; upd = u;
    exp = ref_model(o, int'(av), int'(bv), mflags);
    #1;
    checks++;
    if (result !== exp[11:4]) begin
      fails++;
      $display("FAIL %s result op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               rtag(o), o, av, bv, result, exp[11:4]);
    end
    @(posedge clk);
    #1;
    if (u) mflags = exp[3:0];
    checks++;
    if ({fn, fz, fc, fv} !== mflags) begin
      fails++;
      $display("FAIL %s flags op=%0d a=%02h b=%02h upd=%0d actual=%04b expected=%04b",
               u ? rtag(o) : "R10", o, av, bv, u, {fn, fz, fc, fv}, mflags);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op = 4'd0; a = 8'h00; b = 8'h00; upd = 1'b0;
    mflags = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    checks++; // R10 reset state
    if ({fn, fz, fc, fv} !== 4'b0000) begin
      fails++;
      $display("FAIL R10 reset flags actual=%04b expected=0000", {fn, fz, fc, fv});
    end
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    step(4'd0, 8'h7F, 8'h01, 1'b1); // R2 signed overflow, no carry
    step(4'd0, 8'h80, 8'h80, 1'b1); // R1 carry, R2 overflow
    step(4'd0, 8'hFF, 8'h00, 1'b1); // R1 carry-in wraps to zero, R9
    step(4'd1, 8'h00, 8'h01, 1'b1); // R3 borrow with C=1
    step(4'd1, 8'h00, 8'h01, 1'b1); // R3 borrow with C=0
    step(4'd1, 8'h80, 8'h01, 1'b1); // R3 signed overflow
    step(4'd11, 8'h40, 8'h40, 1'b1); // R8 equal
    step(4'd11, 8'h41, 8'h40, 1'b1); // R8 larger
    step(4'd11, 8'h3F, 8'h40, 1'b1); // R8 smaller
    step(4'd11, 8'h40, 8'h40, 1'b1); // C=1 again
    step(4'd2, 8'hFF, 8'h00, 1'b1);  // R4 increment wraps, C kept
    step(4'd3, 8'h00, 8'h00, 1'b1);  // R4 decrement wraps, C kept
    step(4'd9, 8'h80, 8'h00, 1'b1);  // R7 rotate left through carry
    step(4'd10, 8'h01, 8'h00, 1'b1); // R7 rotate right through carry
    step(4'd7, 8'h81, 8'h00, 1'b1);  // R6 shift left
    step(4'd8, 8'h81, 8'h00, 1'b1);  // R6 shift right
    step(4'd0, 8'h7F, 8'h7F, 1'b0);  // R10 strobe low: flags stay
    step(4'd11, 8'h00, 8'hFF, 1'b0); // R10 strobe low
    step(4'd14, 8'h5A, 8'h00, 1'b1); // R11 unused code

    // sweep every code over every a, eight b values each
    for (int o = 0; o < 16; o++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int j = 0; j < 8; j++) begin
          step(o[3:0], ai[7:0], 8'((ai * 13 + j * 41 + o * 7) % 256), 1'b1);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule